// File: doc/BRIEF.md
# I2C Byte Command Controller

This block is the host-side control unit of an I2C master. A host reaches it through a small byte-wide register file. Two registers hold a 16-bit clock prescale. A control register enables the core and its interrupt. A data register holds the byte to send and, after a read, the byte received. One address is write-only for commands and read-only for status.

A single command write can combine several actions: a start condition, a byte transfer in either direction with the acknowledge choice, and a closing stop. The block turns that write into a sequence of single-bit operations and hands each one to a bit-level engine over a go/done handshake. The bit engine owns the bit timing and the open-drain pads.

The block reports transfer-in-progress, bus busy, arbitration loss and the acknowledge it received. It raises a completion flag after every sequence. The host can poll that flag or take it as an interrupt.

Top module: `i2c_byte_ctl`

## Requirements
- R1: After reset the block reads as follows: prescale low and high bytes 0xFF, control 0x00, data 0x00, status 0x00 while the bus-busy input is low. The interrupt output is low and `prescaleOut` is 0xFFFF.
- R2: Register read offsets are 0 prescale low, 1 prescale high, 2 control, 3 data and 4 status; any other offset reads 0x00. Control bit 7 enables the core and bit 6 enables the interrupt. Control bits 5..0 read as 0.
- R3: The prescale bytes can be written while the core is disabled, and `prescaleOut` equals {high, low}.
- R4: A command write with the core disabled starts no bit operation, and the transfer-in-progress bit (status bit 1) stays 0.
- R5: Command bit 7 (start) issues START and then the byte. Command bit 4 (write) issues eight WRITE operations that carry the data register MSB first, followed by one READ operation that samples the acknowledge. Bit operation codes are NONE=0, START=1, STOP=2, WRITE=3 and READ=4.
- R6: Command bit 5 (read) issues eight READ operations followed by one WRITE operation. That WRITE carries command bit 3 (1 = NACK). When the read completes, the data register holds the received bits, first bit as MSB.
- R7: Command bit 6 (stop) issues STOP after any byte in the same command. A stop alone issues only STOP.
- R8: Status bit 1 is 1 from the cycle after a command is accepted until the sequence ends. Status bit 0 (flag) is then set whatever the interrupt enable holds. Command bits clear themselves, so a sequence never repeats.
- R9: Status bit 7 holds the acknowledge sampled after a written byte; 1 means NACK.
- R10: An arbitration loss reported with a bit completion ends the sequence at once. No further operation is issued, and status bit 5 and the flag are set.
- R11: The interrupt output equals flag AND interrupt enable. The flag clears only on a command write with bit 0 set, or on reset.
- R12: During and after a write, reads of the data register return the value the host last wrote.
- R13: While a sequence runs, command writes that request start, stop, read or write are ignored. Bit 0 (flag clear) is still honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| irqOut | output | 1 | Interrupt request |
| prescaleOut | output | 16 | Prescale value for the bit engine |
| coreEnOut | output | 1 | Core enable for the bit engine |
| bitGo | output | 1 | One-cycle request for a bit operation |
| bitOp | output | 3 | Bit operation code |
| bitTxd | output | 1 | Bit to drive for WRITE |
| bitDone | input | 1 | Bit operation finished |
| bitRxd | input | 1 | Bit sampled by the engine, valid with bitDone |
| bitArbLost | input | 1 | Arbitration lost, valid with bitDone |
| busBusy | input | 1 | Bus busy indication from the engine |

## Verification
The hardest case to reach from the ports is an arbitration loss in the middle of a byte. It happens only when the bit engine reports a loss on one particular bit completion. The bench's engine model therefore counts the operations it serves and raises the loss flag on a chosen one. The scoreboard expects exactly the operations issued before the loss and flags any operation that follows. A command written while a sequence is still running is reached by writing a second command in the cycles right after the first.

// File: rtl/i2c_byte_ctl_pkg.sv
package i2c_byte_ctl_pkg;

  localparam int DATA_W = 8;
  localparam int PRE_W  = 2 * DATA_W;
  localparam int CNT_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4
  } bitOp_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_DATA, SQ_ACK, SQ_STOP
  } seqState_e;

  typedef struct packed {
    logic sta;
    logic sto;
    logic rd;
    logic wr;
    logic nack;
  } cmdBits_t;

  typedef struct packed {
    logic begin_;
    logic shiftBit;
    logic captureAck;
    logic latchRx;
    logic finish;
    logic arbLost;
  } seqStrobe_t;

endpackage

// File: rtl/i2c_byte_ctl_regs.sv
module i2c_byte_ctl_regs
  import i2c_byte_ctl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic [PRE_W-1:0]  prescaleOut,
  output logic              coreEn,
  input  logic              busBusy,
  input  logic              bitRxd,
  input  logic              seqBusy,
  input  seqStrobe_t        strobe,
  output cmdBits_t          cmd,
  output logic              shiftMsb
);

  localparam logic [ADDR_W-1:0] A_PRE_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PRE_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(4);

  logic [DATA_W-1:0] preLo, preHi, dataReg, shiftReg;
  logic              intEn, ifFlag, alFlag, rxNack;
  logic              cmdPending, tip, iackWr, cmdWr;

  assign cmdWr      = regWrEn && (regAddr == A_CMD);
  assign iackWr     = cmdWr && regWrData[0];
  assign cmdPending = cmd.sta | cmd.sto | cmd.rd | cmd.wr;
  assign tip        = seqBusy | cmdPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preLo  <= '1;
      preHi  <= '1;
      coreEn <= 1'b0;
      intEn  <= 1'b0;
    end else if (regWrEn) begin
      if (regAddr == A_PRE_LO) preLo <= regWrData;
      if (regAddr == A_PRE_HI) preHi <= regWrData;
      if (regAddr == A_CTRL) begin
        coreEn <= regWrData[7];
        intEn  <= regWrData[6];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmd <= '0;
    end else if (strobe.finish) begin
      cmd <= '0;
    end else if (cmdWr && coreEn && !tip) begin
      cmd.sta  <= regWrData[7];
      cmd.sto  <= regWrData[6];
      cmd.rd   <= regWrData[5];
      cmd.wr   <= regWrData[4];
      cmd.nack <= regWrData[3];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (regWrEn && regAddr == A_DATA) dataReg <= regWrData;
      if (strobe.latchRx) dataReg <= shiftReg;
      if (strobe.begin_) shiftReg <= dataReg;
      else if (strobe.shiftBit) shiftReg <= {shiftReg[DATA_W-2:0], bitRxd};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifFlag <= 1'b0;
      alFlag <= 1'b0;
      rxNack <= 1'b0;
    end else begin
      if (strobe.finish) ifFlag <= 1'b1;
      else if (iackWr) ifFlag <= 1'b0;
      if (strobe.arbLost) alFlag <= 1'b1;
      else if (strobe.begin_) alFlag <= 1'b0;
      if (strobe.captureAck) rxNack <= bitRxd;
    end
  end

  always_comb begin
    unique case (regAddr)
      A_PRE_LO: regRdData = preLo;
      A_PRE_HI: regRdData = preHi;
      A_CTRL:   regRdData = {coreEn, intEn, 6'b0};
      A_DATA:   regRdData = dataReg;
      A_CMD:    regRdData = {rxNack, busBusy, alFlag, 3'b0, tip, ifFlag};
      default:  regRdData = '0;
    endcase
  end

  assign irqOut      = ifFlag & intEn;
  assign prescaleOut = {preHi, preLo};
  assign shiftMsb    = shiftReg[DATA_W-1];

  // R8: completion raises the flag on the next edge
  assert_flag_on_finish_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> ifFlag);
  // R8: command bits are gone after a finished sequence
  assert_cmd_selfclear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !cmdPending);
  // R11: the flag holds until a clear command
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ifFlag && !iackWr) |=> ifFlag);
  // R4: a disabled core never latches a command
  assert_no_cmd_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!coreEn && !cmdPending && !strobe.finish) |=> !cmdPending);

endmodule

// File: rtl/i2c_byte_ctl_seq.sv
module i2c_byte_ctl_seq
  import i2c_byte_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cmdBits_t   cmd,
  input  logic       coreEn,
  input  logic       shiftMsb,
  input  logic       bitDone,
  input  logic       bitArbLost,
  output logic       bitGo,
  output logic [2:0] bitOp,
  output logic       bitTxd,
  output seqStrobe_t strobe,
  output logic       seqBusy
);

  seqState_e  state, stateNxt;
  logic [CNT_W-1:0] bitCnt;
  logic       launch, launchNxt, cntClr, cntInc, isRead, anyCmd;

  assign isRead = cmd.rd && !cmd.wr;
  assign anyCmd = cmd.sta | cmd.sto | cmd.rd | cmd.wr;

  always_comb begin
    stateNxt  = state;
    launchNxt = 1'b0;
    cntClr    = 1'b0;
    cntInc    = 1'b0;
    strobe    = '0;
    unique case (state)
      SQ_IDLE: begin
        if (coreEn && anyCmd) begin
          strobe.begin_ = 1'b1;
          cntClr        = 1'b1;
          launchNxt     = 1'b1;
          if (cmd.sta) stateNxt = SQ_START;
          else if (cmd.rd || cmd.wr) stateNxt = SQ_DATA;
          else stateNxt = SQ_STOP;
        end
      end
      default: begin
        if (bitDone && bitArbLost) begin
          strobe.arbLost = 1'b1;
          strobe.finish  = 1'b1;
          stateNxt       = SQ_IDLE;
        end else if (bitDone) begin
          launchNxt = 1'b1;
          unique case (state)
            SQ_START: begin
              if (cmd.rd || cmd.wr) stateNxt = SQ_DATA;
              else if (cmd.sto) stateNxt = SQ_STOP;
              else begin
                stateNxt = SQ_IDLE; launchNxt = 1'b0; strobe.finish = 1'b1;
              end
            end
            SQ_DATA: begin
              strobe.shiftBit = 1'b1;
              cntInc          = 1'b1;
              if (bitCnt == CNT_W'(DATA_W - 1)) stateNxt = SQ_ACK;
            end
            SQ_ACK: begin
              strobe.captureAck = !isRead;
              strobe.latchRx    = isRead;
              if (cmd.sto) stateNxt = SQ_STOP;
              else begin
                stateNxt = SQ_IDLE; launchNxt = 1'b0; strobe.finish = 1'b1;
              end
            end
            default: begin
              stateNxt = SQ_IDLE; launchNxt = 1'b0; strobe.finish = 1'b1;
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= SQ_IDLE;
      launch <= 1'b0;
      bitCnt <= '0;
    end else begin
      state  <= stateNxt;
      launch <= launchNxt;
      if (cntClr) bitCnt <= '0;
      else if (cntInc) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    bitOp  = OP_NONE;
    bitTxd = 1'b1;
    unique case (state)
      SQ_START: bitOp = OP_START;
      SQ_STOP:  bitOp = OP_STOP;
      SQ_DATA: begin
        bitOp  = isRead ? OP_READ : OP_WRITE;
        bitTxd = isRead ? 1'b1 : shiftMsb;
      end
      SQ_ACK: begin
        bitOp  = isRead ? OP_WRITE : OP_READ;
        bitTxd = isRead ? cmd.nack : 1'b1;
      end
      default: ;
    endcase
  end

  assign bitGo   = launch;
  assign seqBusy = (state != SQ_IDLE);

  // R5: each request to the bit engine lasts one cycle
  assert_go_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitGo |=> !bitGo);
  // R4: an idle, disabled core issues nothing
  assert_no_go_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == SQ_IDLE && !coreEn) |=> !bitGo);
  // R10: arbitration loss returns the sequencer to idle
  assert_arb_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    (bitDone && bitArbLost && state != SQ_IDLE) |=> (state == SQ_IDLE && !bitGo));

endmodule

// File: rtl/i2c_byte_ctl.sv
module i2c_byte_ctl
  import i2c_byte_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  output logic        irqOut,
  output logic [15:0] prescaleOut,
  output logic        coreEnOut,
  output logic        bitGo,
  output logic [2:0]  bitOp,
  output logic        bitTxd,
  input  logic        bitDone,
  input  logic        bitRxd,
  input  logic        bitArbLost,
  input  logic        busBusy
);

  cmdBits_t   cmd;
  seqStrobe_t strobe;
  logic       shiftMsb, seqBusy;

  i2c_byte_ctl_regs #(.ADDR_W(3)) uRegs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut),
    .prescaleOut(prescaleOut), .coreEn(coreEnOut), .busBusy(busBusy),
    .bitRxd(bitRxd), .seqBusy(seqBusy), .strobe(strobe), .cmd(cmd),
    .shiftMsb(shiftMsb)
  );

  i2c_byte_ctl_seq uSeq (
    .clk(clk), .rstN(rstN), .cmd(cmd), .coreEn(coreEnOut),
    .shiftMsb(shiftMsb), .bitDone(bitDone), .bitArbLost(bitArbLost),
    .bitGo(bitGo), .bitOp(bitOp), .bitTxd(bitTxd), .strobe(strobe),
    .seqBusy(seqBusy)
  );

endmodule

// File: tb/sim_i2c_byte_ctl.sv
module sim_i2c_byte_ctl;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irqOut, coreEnOut, bitGo, bitTxd;
  logic [15:0] prescaleOut;
  logic [2:0] bitOp;
  logic bitDone = 1'b0, bitRxd = 1'b1, bitArbLost = 1'b0, busBusy = 1'b0;

  always #4 clk = ~clk;

  i2c_byte_ctl u0 (.*);

  typedef struct packed { logic [2:0] op; logic txd; logic chkTxd; } expItem_t;
  expItem_t expQ[$];
  logic     rxQ[$];
  int total = 0, bad = 0, goCount = 0, arbAt = 0, opSeen = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pushOp(logic [2:0] op, logic txd, logic chkTxd);
    expQ.push_back({op, txd, chkTxd});
  endtask

  task automatic pushWriteByte(logic [7:0] b, logic ack);
    for (int i = 7; i >= 0; i--) pushOp(3'd3, b[i], 1'b1);
    pushOp(3'd4, 1'b1, 1'b0);
    rxQ.push_back(ack);
  endtask

  task automatic pushReadByte(logic [7:0] b, logic nack);
    for (int i = 7; i >= 0; i--) begin
      pushOp(3'd4, 1'b1, 1'b0);
      rxQ.push_back(b[i]);
    end
    pushOp(3'd3, nack, 1'b1);
  endtask

  task automatic regWr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle(string req);
    logic [7:0] s;
    int n = 0;
    do begin
      @(negedge clk);
      regRd(3'd4, s);
      n++;
    end while (s[1] && n < 2000);
    chk({req, " sequence ends"}, int'(n < 2000), 1);
    @(negedge clk);
  endtask

  // bit engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      bitDone = 1'b0; bitArbLost = 1'b0;
      if (bitGo) begin
        expItem_t e;
        goCount++; opSeen++;
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R5/R13 unexpected op actual=%0d expected=none", bitOp);
        end else begin
          e = expQ.pop_front();
          if (bitOp != e.op || (e.chkTxd && bitTxd != e.txd)) begin
            bad++;
            $display("FAIL R5/R6/R7 op actual=%0d/%0b expected=%0d/%0b",
                     bitOp, bitTxd, e.op, e.txd);
          end
        end
        repeat (3) @(negedge clk);
        bitRxd = (bitOp == 3'd4 && rxQ.size() > 0) ? rxQ.pop_front() : 1'b1;
        bitArbLost = (arbAt != 0 && opSeen == arbAt);
        bitDone = 1'b1;
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regRd(3'd0, r); chk("R1 prelo", r, 8'hFF);
    regRd(3'd1, r); chk("R1 prehi", r, 8'hFF);
    regRd(3'd2, r); chk("R1 ctrl", r, 8'h00);
    regRd(3'd3, r); chk("R1 data", r, 8'h00);
    regRd(3'd4, r); chk("R1 status", r, 8'h00);
    chk("R1 irq", irqOut, 0);
    chk("R1 prescale", prescaleOut, 16'hFFFF);
    // R3/R2 prescale while disabled
    regWr(3'd0, 8'h34); regWr(3'd1, 8'h12);
    regRd(3'd0, r); chk("R2 prelo readback", r, 8'h34);
    regRd(3'd1, r); chk("R2 prehi readback", r, 8'h12);
    chk("R3 prescaleOut", prescaleOut, 16'h1234);
    regRd(3'd6, r); chk("R2 unused offset", r, 8'h00);
    // R4 command while disabled
    regWr(3'd3, 8'hA4); regWr(3'd4, 8'h90);
    regRd(3'd4, r); chk("R4 tip stays 0", r[1], 0);
    repeat (20) @(negedge clk);
    chk("R4 no bit ops", goCount, 0);
    // R2 control
    regWr(3'd2, 8'hFF);
    regRd(3'd2, r); chk("R2 ctrl reads en/ien only", r, 8'hC0);
    regWr(3'd2, 8'h80);
    chk("R2 core enable out", coreEnOut, 1);
    // R5 start + write, ack
    pushOp(3'd1, 1'b1, 1'b0); pushWriteByte(8'hA4, 1'b0);
    regWr(3'd4, 8'h90);
    regRd(3'd4, r); chk("R8 tip set after accept", r[1], 1);
    regRd(3'd3, r); chk("R12 data during write", r, 8'hA4);
    waitIdle("R5");
    regRd(3'd4, r); chk("R8 flag set, R9 ack", r, 8'h01);
    chk("R11 irq masked", irqOut, 0);
    chk("R5 all ops issued", expQ.size(), 0);
    regRd(3'd3, r); chk("R12 data after write", r, 8'hA4);
    regWr(3'd4, 8'h01);
    regRd(3'd4, r); chk("R11 flag cleared", r[0], 0);
    // R9 write with NACK, R13 ignored command during busy
    regWr(3'd3, 8'h3C);
    pushWriteByte(8'h3C, 1'b1);
    regWr(3'd4, 8'h10);
    regWr(3'd4, 8'h40);
    waitIdle("R13");
    regRd(3'd4, r); chk("R9 nack bit", r[7], 1);
    chk("R13 busy write ignored", expQ.size(), 0);
    // R13 clear honoured while busy
    pushWriteByte(8'h3C, 1'b0);
    regWr(3'd4, 8'h10);
    regWr(3'd4, 8'h01);
    regRd(3'd4, r); chk("R13 iack while busy", r[0], 0);
    waitIdle("R13b");
    // R6 read with NACK and stop, R11 irq
    regWr(3'd4, 8'h01);
    regWr(3'd2, 8'hC0);
    pushReadByte(8'h5A, 1'b1); pushOp(3'd2, 1'b1, 1'b0);
    regWr(3'd4, 8'h68);
    waitIdle("R6");
    regRd(3'd3, r); chk("R6 received byte", r, 8'h5A);
    chk("R11 irq on", irqOut, 1);
    chk("R7 stop after byte", expQ.size(), 0);
    regWr(3'd4, 8'h01);
    chk("R11 irq off after clear", irqOut, 0);
    // R6 read with ACK
    pushReadByte(8'hC3, 1'b0);
    regWr(3'd4, 8'h20);
    waitIdle("R6b");
    regRd(3'd3, r); chk("R6 received byte ack", r, 8'hC3);
    regWr(3'd4, 8'h01);
    // R7 stop alone
    pushOp(3'd2, 1'b1, 1'b0);
    regWr(3'd4, 8'h40);
    waitIdle("R7");
    chk("R7 stop only", expQ.size(), 0);
    regWr(3'd4, 8'h01);
    // R10 arbitration loss on third op
    regWr(3'd3, 8'hA4);
    opSeen = 0; arbAt = 3;
    pushOp(3'd1, 1'b1, 1'b0); pushOp(3'd3, 1'b1, 1'b1); pushOp(3'd3, 1'b0, 1'b1);
    regWr(3'd4, 8'h90);
    waitIdle("R10");
    arbAt = 0;
    repeat (10) @(negedge clk);
    regRd(3'd4, r); chk("R10 al and flag", r & 8'h21, 8'h21);
    chk("R10 no further ops", expQ.size(), 0);
    busBusy = 1'b1; #1;
    regRd(3'd4, r); chk("R2 busy bit", r[6], 1);
    busBusy = 1'b0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule